// File: doc/BRIEF.md
# Receive Character FIFO with Block Thresholds, End-Character Detection and DMA Request

This block sits between an asynchronous character receiver and a host bus. Each character the receiver delivers is stored in a 32-entry byte queue. The host pulls entries from the head through a 32-address read window, and every address in that window returns the same head entry. The host chooses how many entries make up a block: 2, 4, 16 or 32. It also sets an end character that closes a block early, and it selects one of two ways to be told that data is waiting.

In interrupt mode the block raises a pool-full interrupt when a threshold's worth of characters is stored. It raises an end-character interrupt when the stored end character falls within one threshold of the head. In both cases it latches the number of entries the host must read. In DMA mode the block drives a level request instead, for exactly one block: a threshold's worth of entries, or the entries up to and including the end character. After an end-character block it raises the end-character interrupt and refuses further requests until the host issues a release command. A forced-read command latches the current fill level, so the host can empty a partial block at any time.

Top module: `rx_char_fifo`

## Requirements
- R1: Entries are read in arrival order. A read pulse with the window bit (host_addr[5]) clear removes the head, and the removed entry appears on rd_data on the next clock. A read of an empty queue changes nothing.
- R2: Every address whose bit 5 is clear returns the same head entry. A read pulse with bit 5 set removes nothing.
- R3: A character that arrives while 32 entries are stored is discarded, and rx_overrun is set. The release command clears rx_overrun.
- R4: fifo_not_empty is high exactly when at least one entry is stored.
- R5: cfg_thresh selects the block size: code 0 is 2, code 1 is 4, code 2 is 16 and code 3 is 32. In interrupt mode (cfg_dma_mode=0), with no interrupt pending, a stored count at or above the block size sets irq_pool_full one clock later, and byte_count is loaded with the block size.
- R6: In interrupt mode, a stored end character whose distance from the head is at most the block size sets irq_term, with no interrupt pending. byte_count is loaded with the number of entries up to and including that character. This takes precedence over R5.
- R7: cmd_force loads byte_count with the number of entries stored in that cycle.
- R8: In DMA mode (cfg_dma_mode=1), dma_req rises once a block is stored. It stays high until the read that completes the block is accepted, so a controller that reads while it sees dma_req transfers exactly the block size.
- R9: In DMA mode, an end-character block keeps dma_req high until the end character itself is read. irq_term is then set, and byte_count holds that block's length.
- R10: After an R9 block, dma_req stays low whatever is stored, until cmd_release is given.
- R11: After reset the queue is empty and all outputs are zero.
- R12: cmd_release clears irq_pool_full and irq_term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Receiver presents a character this cycle |
| rx_data | input | 8 | Received character |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Host address; bit 5 clear selects the queue window |
| rd_data | output | 8 | Entry removed by the last accepted read |
| cmd_force | input | 1 | Forced-read command: latch current fill level |
| cmd_release | input | 1 | Release command: clear interrupts, overrun and DMA lockout |
| cfg_dma_mode | input | 1 | 0 interrupt mode, 1 DMA mode |
| cfg_thresh | input | 2 | Block size code |
| cfg_term_char | input | 8 | End character |
| fifo_not_empty | output | 1 | Queue holds at least one entry |
| byte_count | output | 6 | Number of valid entries for the host |
| irq_pool_full | output | 1 | Threshold interrupt |
| irq_term | output | 1 | End-character interrupt |
| rx_overrun | output | 1 | A character was discarded while the queue was full |
| dma_req | output | 1 | Level DMA request |

## Verification
The risky coincidence is a receiver write landing in the same cycle as a host read. The sharpest form is an end character that arrives while the read removes the head: the end character's distance then has to account for both changes at once. The bench provokes this by issuing write and read in the same cycle, including with the end character as the written byte. It then judges the resulting interrupt, byte_count and the order of the later reads against a queue-based model that is compared on every clock. DMA bursts are drained by a bench agent that reads only while dma_req is high, so an early or late fall of the request shows up as a wrong transfer count.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  typedef enum logic [1:0] {
    THR_TWO  = 2'd0,
    THR_FOUR = 2'd1,
    THR_HALF = 2'd2,
    THR_FULL = 2'd3
  } thr_code_e;

  // Block size for a threshold code; the upper two levels scale with depth.
  function automatic int unsigned thr_level(input logic [1:0] code, input int unsigned depth);
    case (thr_code_e'(code))
      THR_TWO:  return 2;
      THR_FOUR: return 4;
      THR_HALF: return depth / 2;
      default:  return depth;
    endcase
  endfunction

endpackage

// File: rtl/rcf_store.sv
module rcf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) begin
        rd_ptr  <= rd_ptr + AW'(1);
        rd_data <= mem[rd_ptr];
      end
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> count < CW'(DEPTH))
    else $error("write accepted into a full queue");

  p_read_nonempty_r1: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0)
    else $error("read accepted from an empty queue");

endmodule

// File: rtl/rcf_term.sv
module rcf_term #(
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] term_char,
  input  logic          rd_en,
  input  logic [CW-1:0] count,
  output logic          hold,
  output logic [CW-1:0] left
);

  // Tracks the oldest stored end character: 'left' is its 1-based distance from the head.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= 1'b0;
      left <= '0;
    end else if (hold) begin
      if (rd_en) begin
        left <= left - CW'(1);
        if (left == CW'(1)) hold <= 1'b0;
      end
    end else if (wr_en && wr_data == term_char) begin
      hold <= 1'b1;
      left <= count + CW'(1) - CW'(rd_en);
    end
  end

  p_term_in_queue_r6: assert property (@(posedge clk) disable iff (rst)
    hold |-> (left != '0 && left <= count))
    else $error("end-character position outside stored data");

endmodule

// File: rtl/rcf_ctrl.sv
module rcf_ctrl #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_mode,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] count,
  input  logic          term_hold,
  input  logic [CW-1:0] term_left,
  input  logic          rd_en,
  input  logic          drop,
  input  logic          cmd_force,
  input  logic          cmd_release,
  output logic [CW-1:0] byte_count,
  output logic          irq_pf,
  output logic          irq_tc,
  output logic          ovf,
  output logic          dma_req
);

  logic [CW-1:0] bleft, blen, bleft_n, start_len;
  logic          tburst, lock;
  logic          st_term, st_thr, dma_start, int_fire, burst_rd, burst_end;

  always_comb begin
    st_term   = term_hold && (term_left <= thr);
    st_thr    = count >= thr;
    start_len = st_term ? term_left : thr;
    dma_start = dma_mode && bleft == '0 && !lock && !rd_en && (st_term || st_thr);
    int_fire  = !dma_mode && !cmd_release && !irq_pf && !irq_tc && (st_term || st_thr);
    burst_rd  = rd_en && bleft != '0;
    burst_end = burst_rd && bleft == CW'(1) && tburst;
    if (dma_start)     bleft_n = start_len;
    else if (burst_rd) bleft_n = bleft - CW'(1);
    else               bleft_n = bleft;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bleft      <= '0;
      blen       <= '0;
      tburst     <= 1'b0;
      lock       <= 1'b0;
      byte_count <= '0;
      irq_pf     <= 1'b0;
      irq_tc     <= 1'b0;
      ovf        <= 1'b0;
      dma_req    <= 1'b0;
    end else begin
      bleft   <= bleft_n;
      dma_req <= bleft_n != '0;
      if (cmd_force) byte_count <= count;
      if (cmd_release) begin
        irq_pf <= 1'b0;
        irq_tc <= 1'b0;
        lock   <= 1'b0;
        ovf    <= 1'b0;
      end
      if (drop) ovf <= 1'b1;
      if (int_fire) begin
        if (st_term) begin
          irq_tc     <= 1'b1;
          byte_count <= term_left;
        end else begin
          irq_pf     <= 1'b1;
          byte_count <= thr;
        end
      end
      if (dma_start) begin
        blen       <= start_len;
        tburst     <= st_term;
        byte_count <= start_len;
      end
      if (burst_end) begin
        irq_tc     <= 1'b1;
        lock       <= 1'b1;
        byte_count <= blen;
      end
    end
  end

  p_req_falls_on_read_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(dma_req) |-> $past(rd_en))
    else $error("DMA request withdrawn without a read");

  p_term_irq_after_read_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> ($past(rd_en) && irq_tc))
    else $error("DMA block closed without final read");

  p_lock_blocks_req_r10: assert property (@(posedge clk) disable iff (rst)
    lock |-> !dma_req)
    else $error("DMA request while locked");

  p_pf_irq_mode_only_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pf) |-> $past(!dma_mode))
    else $error("pool-full interrupt in DMA mode");

  p_drop_flags_r3: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf)
    else $error("discarded character not flagged");

endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rcf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          host_rd,
  input  logic [AW:0]   host_addr,
  output logic [DW-1:0] rd_data,
  input  logic          cmd_force,
  input  logic          cmd_release,
  input  logic          cfg_dma_mode,
  input  logic [1:0]    cfg_thresh,
  input  logic [DW-1:0] cfg_term_char,
  output logic          fifo_not_empty,
  output logic [CW-1:0] byte_count,
  output logic          irq_pool_full,
  output logic          irq_term,
  output logic          rx_overrun,
  output logic          dma_req
);

  logic [CW-1:0] count, thr, term_left;
  logic          wr_en, rd_en, drop, term_hold;
  logic          unused_addr_low;

  // all addresses inside the window alias onto the head entry
  assign unused_addr_low = ^host_addr[AW-1:0];
  assign rd_en           = host_rd && !host_addr[AW] && count != '0;
  assign wr_en           = rx_valid && count != CW'(DEPTH);
  assign drop            = rx_valid && count == CW'(DEPTH);
  assign thr             = CW'(thr_level(cfg_thresh, DEPTH));
  assign fifo_not_empty  = count != '0;

  rcf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (rx_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .count   (count)
  );

  rcf_term #(.DW(DW), .CW(CW)) u_term (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (rx_data),
    .term_char (cfg_term_char),
    .rd_en     (rd_en),
    .count     (count),
    .hold      (term_hold),
    .left      (term_left)
  );

  rcf_ctrl #(.CW(CW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .dma_mode    (cfg_dma_mode),
    .thr         (thr),
    .count       (count),
    .term_hold   (term_hold),
    .term_left   (term_left),
    .rd_en       (rd_en),
    .drop        (drop),
    .cmd_force   (cmd_force),
    .cmd_release (cmd_release),
    .byte_count  (byte_count),
    .irq_pf      (irq_pool_full),
    .irq_tc      (irq_term),
    .ovf         (rx_overrun),
    .dma_req     (dma_req)
  );

  p_empty_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && count == CW'(1)) |=> !fifo_not_empty)
    else $error("not-empty flag stuck after last read");

endmodule

// File: tb/rx_char_fifo_tb.sv
module rx_char_fifo_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 0, host_rd = 0, cmd_force = 0, cmd_release = 0, dma_mode = 0;
  logic [7:0] rx_data = 0, term_char = 8'hFF;
  logic [5:0] host_addr = 0;
  logic [1:0] thr_code = 0;
  logic [7:0] rd_data;
  logic [5:0] byte_count;
  logic       not_empty, irq_pf, irq_tc, ovf, dma_req;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_char_fifo u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .host_rd(host_rd), .host_addr(host_addr), .rd_data(rd_data),
    .cmd_force(cmd_force), .cmd_release(cmd_release),
    .cfg_dma_mode(dma_mode), .cfg_thresh(thr_code), .cfg_term_char(term_char),
    .fifo_not_empty(not_empty), .byte_count(byte_count),
    .irq_pool_full(irq_pf), .irq_term(irq_tc), .rx_overrun(ovf), .dma_req(dma_req)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_q[$];
  int  m_bc, m_bleft, m_blen, m_tleft;
  bit  m_pf, m_tc, m_ovf, m_lock, m_tburst, m_hold, m_req;
  logic [7:0] m_rdata;

  function automatic int blk_size(input logic [1:0] c);
    case (c)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 16;
      default: return 32;
    endcase
  endfunction

  always @(posedge clk) begin
    int c, t, ln;
    bit rd, wr, drop, st_term, st_thr, dstart, ifire, brd, bend;
    if (rst) begin
      m_q.delete();
      m_bc = 0; m_bleft = 0; m_blen = 0; m_tleft = 0;
      m_pf = 0; m_tc = 0; m_ovf = 0; m_lock = 0; m_tburst = 0; m_hold = 0; m_req = 0;
      m_rdata = 0;
    end else begin
      c = m_q.size();
      t = blk_size(thr_code);
      rd = host_rd && !host_addr[5] && c > 0;
      wr = rx_valid && c < 32;
      drop = rx_valid && c == 32;
      st_term = m_hold && m_tleft <= t;
      st_thr = c >= t;
      dstart = dma_mode && m_bleft == 0 && !m_lock && !rd && (st_term || st_thr);
      ifire = !dma_mode && !cmd_release && !m_pf && !m_tc && (st_term || st_thr);
      brd = rd && m_bleft > 0;
      bend = brd && m_bleft == 1 && m_tburst;
      if (cmd_force) m_bc = c;
      if (cmd_release) begin m_pf = 0; m_tc = 0; m_lock = 0; m_ovf = 0; end
      if (drop) m_ovf = 1;
      if (ifire) begin
        if (st_term) begin m_tc = 1; m_bc = m_tleft; end
        else begin m_pf = 1; m_bc = t; end
      end
      if (dstart) begin
        ln = st_term ? m_tleft : t;
        m_blen = ln; m_tburst = st_term; m_bc = ln; m_bleft = ln;
      end else if (brd) m_bleft--;
      if (bend) begin m_tc = 1; m_lock = 1; m_bc = m_blen; end
      if (m_hold) begin
        if (rd) begin m_tleft--; if (m_tleft == 0) m_hold = 0; end
      end else if (wr && rx_data == term_char) begin
        m_hold = 1; m_tleft = c + 1 - (rd ? 1 : 0);
      end
      if (rd) m_rdata = m_q.pop_front();
      if (wr) m_q.push_back(rx_data);
      m_req = m_bleft != 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 rd_data", rd_data, m_rdata);
      chk("R4 fifo_not_empty", not_empty, m_q.size() != 0);
      chk("R3 rx_overrun", ovf, m_ovf);
      chk("R5 irq_pool_full", irq_pf, m_pf);
      chk("R6 irq_term", irq_tc, m_tc);
      chk("R7 byte_count", byte_count, m_bc);
      chk("R8 dma_req", dma_req, m_req);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    rx_valid = 1; rx_data = d; @(negedge clk); rx_valid = 0;
  endtask

  task automatic pop(input logic [5:0] a);
    host_rd = 1; host_addr = a; @(negedge clk); host_rd = 0;
  endtask

  task automatic pop_chk(input logic [5:0] a, input logic [7:0] exp, input string tag);
    pop(a);
    chk(tag, rd_data, exp);
  endtask

  task automatic both(input logic [7:0] d, input logic [5:0] a);
    rx_valid = 1; rx_data = d; host_rd = 1; host_addr = a;
    @(negedge clk);
    rx_valid = 0; host_rd = 0;
  endtask

  task automatic release_cmd();
    cmd_release = 1; @(negedge clk); cmd_release = 0;
  endtask

  task automatic drain(output int n);
    n = 0;
    while (dma_req) begin pop(6'd3); n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 not_empty", not_empty, 0);
    chk("R11 byte_count", byte_count, 0);
    chk("R11 dma_req", dma_req, 0);
    chk("R11 irqs", {irq_pf, irq_tc, ovf}, 0);

    // R5 pool-full with block of 4, R2 aliasing
    thr_code = 2'd1; term_char = 8'hFF;
    push(8'h10); push(8'h11); push(8'h12); push(8'h13);
    idle(2);
    chk("R5 pool-full set", irq_pf, 1);
    chk("R5 byte_count", byte_count, 4);
    pop(6'h20);                          // outside window, ignored
    chk("R2 outside window keeps entries", not_empty, 1);
    pop_chk(6'd0, 8'h10, "R2 addr 0");
    pop_chk(6'd7, 8'h11, "R2 addr 7");
    pop_chk(6'd19, 8'h12, "R2 addr 19");
    pop_chk(6'd31, 8'h13, "R2 addr 31");
    release_cmd();
    chk("R12 pool-full cleared", irq_pf, 0);
    chk("R4 empty", not_empty, 0);
    pop(6'd0);                           // empty read ignored
    chk("R1 empty read no change", rd_data, 8'h13);

    // R6 end character in interrupt mode
    thr_code = 2'd2; term_char = 8'h0D;
    push(8'h41); push(8'h42); push(8'h0D);
    idle(2);
    chk("R6 irq_term", irq_tc, 1);
    chk("R6 byte_count", byte_count, 3);
    pop_chk(6'd1, 8'h41, "R1 order");
    pop_chk(6'd2, 8'h42, "R1 order");
    pop_chk(6'd3, 8'h0D, "R6 end char read");
    release_cmd();
    chk("R12 irq_term cleared", irq_tc, 0);

    // R7 forced read
    for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
    cmd_force = 1; @(negedge clk); cmd_force = 0;
    chk("R7 forced count", byte_count, 5);
    for (int i = 0; i < 5; i++) pop_chk(6'd9, 8'h30 + 8'(i), "R1 forced drain");

    // R3 overrun with block of 32
    thr_code = 2'd3;
    for (int i = 0; i < 33; i++) push(8'h40 + 8'(i));
    idle(1);
    chk("R3 overrun set", ovf, 1);
    chk("R5 full block count", byte_count, 32);
    for (int i = 0; i < 32; i++) pop_chk(6'd5, 8'h40 + 8'(i), "R3 kept entries");
    chk("R3 dropped char absent", not_empty, 0);
    release_cmd();
    chk("R3 overrun cleared", ovf, 0);

    // simultaneous write and read, end char arriving with a read
    push(8'h21); push(8'h22); push(8'h23);
    both(8'h24, 6'd0);
    both(8'h0D, 6'd0);
    idle(2);
    chk("R6 end char with read", irq_tc, 1);
    chk("R6 distance with read", byte_count, 3);
    pop_chk(6'd0, 8'h23, "R1 after overlap");
    pop_chk(6'd0, 8'h24, "R1 after overlap");
    pop_chk(6'd0, 8'h0D, "R1 after overlap");
    release_cmd();

    // R8 DMA blocks of 2
    dma_mode = 1; thr_code = 2'd0;
    for (int i = 0; i < 5; i++) push(8'h50 + 8'(i));
    idle(1);
    drain(n); chk("R8 first burst length", n, 2);
    idle(2);
    drain(n); chk("R8 second burst length", n, 2);
    idle(2);
    chk("R8 no request below block", dma_req, 0);
    pop_chk(6'd0, 8'h54, "R1 leftover");

    // R9/R10 DMA end-character block and lockout
    thr_code = 2'd2;
    push(8'h61); push(8'h62); push(8'h0D); push(8'h64);
    idle(2);
    drain(n); chk("R9 burst up to end char", n, 3);
    chk("R9 rd_data end char", rd_data, 8'h0D);
    idle(1);
    chk("R9 irq_term after block", irq_tc, 1);
    chk("R9 byte_count", byte_count, 3);
    for (int i = 0; i < 16; i++) push(8'h80 + 8'(i));
    idle(3);
    chk("R10 locked out", dma_req, 0);
    release_cmd();
    idle(2);
    chk("R10 request after release", dma_req, 1);
    drain(n); chk("R10 burst after release", n, 16);
    pop_chk(6'd0, 8'h8F, "R1 last entry");
    release_cmd();
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule